// File: doc/BRIEF.md
# Segmenting Gigabit Ethernet Receive MAC

This block sits directly behind the byte-wide receive interface of a Gigabit Ethernet PHY. It runs at the 125 MHz byte clock and takes one byte per cycle with a valid and an error qualifier. It finds the start of each frame by hunting for the preamble and the start-of-frame delimiter. It forwards the frame body from the destination address through the payload and holds back the four trailing check bytes. Bytes go out in cut-through fashion on a byte-wide stream. The stream is cut into fixed 64-byte segments, so a segment takes 512 ns at line rate.

Each output byte carries its segment number and a flag for the first segment. The last byte of each segment carries a segment-end flag. The last byte of the frame carries an extra frame-end flag. When a frame ends, a one-cycle sideband record reports the following:
- the timestamp captured when the delimiter arrived
- the received length
- the CRC result
- receive-error and length-error flags
- whether the frame was a flow-control pause request, and its quanta
- whether the frame should be routed rather than bridged

The route decision compares the upper 64 bits of an IPv6 destination address against a small table of enabled prefixes.

Top module: `rx_seg_mac`

## Requirements
- R1: A frame starts only after one or more 0x55 bytes followed by 0xD5, with `rx_valid` high throughout. Any other byte in that position makes the block ignore the whole burst until `rx_valid` falls. It then emits no data and no sideband.
- R2: The bytes after the delimiter appear on `m_tdata` in order, except the last four bytes of the frame, which are never emitted. A frame with N bytes after the delimiter yields max(N-4,0) output beats.
- R3: `m_tlast` is high on every 64th beat of a frame and on its final beat. `m_seg_idx` counts segments from 0. `m_seg_first` is high on every beat of segment 0. `m_seg_last` is high only on the final beat of the frame.
- R4: `sb_ts` equals the `ts_in` value sampled on the clock edge that accepted the 0xD5 byte.
- R5: `sb_fcs_ok` is high when a CRC-32 over all bytes after the delimiter leaves the residue 0xC704DD7B. The CRC uses polynomial 0x04C11DB7, reflected, with all-ones preset. The residue is given in MSB-first form. A bad CRC does not suppress any data.
- R6: `sb_len` is the count of bytes after the delimiter. `sb_len_err` is high when that count is below 64 or above 1518.
- R7: `sb_rx_err` is high when `rx_err` was high on any byte after the delimiter. The data is still forwarded.
- R8: `sb_pause` is high only for a pause frame that also has a good CRC and no receive error. A pause frame has destination 01-80-C2-00-00-01 (bytes 0-5), type 0x8808 (bytes 12-13) and opcode 0x0001 (bytes 14-15). `sb_quanta` is then bytes 16-17, most significant byte first.
- R9: `sb_route` is high when bytes 12-13 are 0x86DD and bytes 38-45 equal `pfx_addr[k]` for some k with `pfx_en[k]` high. Byte 38 is compared against bits 63:56 of the entry. Otherwise the frame is bridged (`sb_route` low).
- R10: `sb_valid` pulses for one cycle per accepted frame, two clock edges after the first cycle with `rx_valid` low. It falls in the same cycle as the frame's final data beat, if the frame has one. After reset, `m_tvalid` and `sb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz byte clock |
| rst | input | 1 | synchronous active-high reset |
| rx_valid | input | 1 | receive byte qualifier; low between frames |
| rx_data | input | 8 | receive byte |
| rx_err | input | 1 | PHY receive error for the current byte |
| ts_in | input | TS_W | free-running timestamp |
| pfx_addr | input | NPFX x 64 | IPv6 routing prefixes |
| pfx_en | input | NPFX | enable per prefix entry |
| m_tvalid | output | 1 | output beat valid |
| m_tdata | output | 8 | output byte |
| m_tlast | output | 1 | last beat of a segment |
| m_seg_idx | output | SEG_IDX_W | segment number within the frame |
| m_seg_first | output | 1 | beat belongs to segment 0 |
| m_seg_last | output | 1 | final beat of the frame |
| sb_valid | output | 1 | per-frame sideband strobe |
| sb_ts | output | TS_W | delimiter arrival timestamp |
| sb_len | output | CNT_W | bytes after the delimiter (saturating) |
| sb_fcs_ok | output | 1 | CRC residue correct |
| sb_rx_err | output | 1 | receive error seen |
| sb_len_err | output | 1 | length out of range |
| sb_pause | output | 1 | valid pause request |
| sb_quanta | output | 16 | pause quanta |
| sb_route | output | 1 | route (1) or bridge (0) |

## Verification
The assertions check the segment framing on every cycle:
- `m_tlast` on the 64th beat and never early inside a frame
- segment 0 flagged as first
- the frame-end beat coinciding with the sideband strobe
- the sideband strobe lasting one cycle
- short frames always flagged as length errors
- pause reports only with a clean CRC

The bench scenarios show the rest:
- byte-exact payload with the check bytes removed, across a sweep of lengths that crosses many segment boundaries
- the CRC verdict and the delimiter timestamp
- rejection of bad preambles
- the pause and route decoders, which depend on specific header contents

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  localparam logic [7:0]  PRE_BYTE   = 8'h55;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
  // Residue of the LSB-first register, the bit reverse of 0xC704DD7B.
  localparam logic [31:0] CRC_GOOD   = 32'hDEBB_20E3;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam int          FCS_BYTES  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_DROP} rx_state_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxm_crc.sv
module rxm_crc
  import rxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       en,
  input  logic [7:0] data,
  output logic       good
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || start) crc_q <= CRC_PRESET;
    else if (en)      crc_q <= crc_step(crc_q, data);
  end

  assign good = (crc_q == CRC_GOOD);
endmodule

// File: rtl/rxm_classify.sv
module rxm_classify #(
  parameter int CNT_W = 11,
  parameter int NPFX  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 en,
  input  logic [CNT_W-1:0]     idx,
  input  logic [7:0]           data,
  input  logic [NPFX-1:0][63:0] pfx_addr,
  input  logic [NPFX-1:0]      pfx_en,
  output logic                 pause_hit,
  output logic [15:0]          quanta,
  output logic                 route_hit
);
  localparam logic [47:0]      PAUSE_DA  = 48'h0180_C200_0001;
  localparam logic [CNT_W-1:0] I_DA_END  = CNT_W'(5);
  localparam logic [CNT_W-1:0] I_TYPE_HI = CNT_W'(12);
  localparam logic [CNT_W-1:0] I_TYPE_LO = CNT_W'(13);
  localparam logic [CNT_W-1:0] I_OP_HI   = CNT_W'(14);
  localparam logic [CNT_W-1:0] I_OP_LO   = CNT_W'(15);
  localparam logic [CNT_W-1:0] I_Q_HI    = CNT_W'(16);
  localparam logic [CNT_W-1:0] I_Q_LO    = CNT_W'(17);
  localparam logic [CNT_W-1:0] I_PFX_LO  = CNT_W'(38);
  localparam logic [CNT_W-1:0] I_PFX_HI  = CNT_W'(45);

  logic da_ok_q, ty_pause_q, ty_v6_q, op_ok_q, q_seen_q, pfx_seen_q;
  logic [NPFX-1:0] pfx_ok_q;
  logic [7:0] da_byte;
  logic [2:0] da_off, pfx_off;

  assign da_off  = 3'd5 - idx[2:0];
  assign da_byte = PAUSE_DA[{da_off, 3'b000} +: 8];
  assign pfx_off = I_PFX_HI[2:0] - idx[2:0];

  always_ff @(posedge clk) begin
    if (rst || start) begin
      da_ok_q    <= 1'b1;
      ty_pause_q <= 1'b1;
      ty_v6_q    <= 1'b1;
      op_ok_q    <= 1'b1;
      q_seen_q   <= 1'b0;
      pfx_seen_q <= 1'b0;
      quanta     <= '0;
    end else if (en) begin
      if (idx <= I_DA_END && data != da_byte) da_ok_q <= 1'b0;
      if (idx == I_TYPE_HI) begin
        if (data != 8'h88) ty_pause_q <= 1'b0;
        if (data != 8'h86) ty_v6_q    <= 1'b0;
      end
      if (idx == I_TYPE_LO) begin
        if (data != 8'h08) ty_pause_q <= 1'b0;
        if (data != 8'hDD) ty_v6_q    <= 1'b0;
      end
      if (idx == I_OP_HI && data != 8'h00) op_ok_q <= 1'b0;
      if (idx == I_OP_LO && data != 8'h01) op_ok_q <= 1'b0;
      if (idx == I_Q_HI) quanta[15:8] <= data;
      if (idx == I_Q_LO) begin
        quanta[7:0] <= data;
        q_seen_q    <= 1'b1;
      end
      if (idx == I_PFX_HI) pfx_seen_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NPFX; g++) begin : g_pfx
    always_ff @(posedge clk) begin
      if (rst || start) pfx_ok_q[g] <= 1'b1;
      else if (en && idx >= I_PFX_LO && idx <= I_PFX_HI &&
               data != pfx_addr[g][{pfx_off, 3'b000} +: 8])
        pfx_ok_q[g] <= 1'b0;
    end
  end

  assign pause_hit = da_ok_q && ty_pause_q && op_ok_q && q_seen_q;
  assign route_hit = ty_v6_q && pfx_seen_q && |(pfx_ok_q & pfx_en);
endmodule

// File: rtl/rxm_seg.sv
module rxm_seg #(
  parameter int SEG_BYTES = 64,
  parameter int SEG_IDX_W = 5,
  parameter int HOLD      = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 push,
  input  logic                 fin,
  input  logic [7:0]           din,
  output logic                 o_valid,
  output logic [7:0]           o_data,
  output logic                 o_last,
  output logic [SEG_IDX_W-1:0] o_idx,
  output logic                 o_first,
  output logic                 o_end
);
  localparam int POS_W  = $clog2(SEG_BYTES);
  localparam int FILL_W = $clog2(HOLD + 1);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(SEG_BYTES - 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HOLD);

  logic [HOLD-1:0][7:0]  hold_q;
  logic [FILL_W-1:0]     fill_q;
  logic [POS_W-1:0]      pos_q;
  logic [SEG_IDX_W-1:0]  idx_q;
  logic full, emit, seg_end;

  assign full    = (fill_q == FILL_FULL);
  assign emit    = full && (push || fin);
  assign seg_end = fin || (pos_q == POS_LAST);

  always_ff @(posedge clk) begin
    if (push) hold_q <= {hold_q[HOLD-2:0], din};
    if (rst || start || fin) begin
      fill_q <= '0;
      pos_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (push && !full) fill_q <= fill_q + 1'b1;
      if (emit) begin
        if (seg_end) begin
          pos_q <= '0;
          idx_q <= idx_q + 1'b1;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_last  <= 1'b0;
      o_idx   <= '0;
      o_first <= 1'b0;
      o_end   <= 1'b0;
    end else begin
      o_valid <= emit;
      if (emit) begin
        o_data  <= hold_q[HOLD-1];
        o_last  <= seg_end;
        o_end   <= fin;
        o_first <= (idx_q == '0);
        o_idx   <= idx_q;
      end else begin
        o_last  <= 1'b0;
        o_end   <= 1'b0;
        o_first <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_seg_mac.sv
module rx_seg_mac
  import rxm_pkg::*;
#(
  parameter int TS_W      = 32,
  parameter int NPFX      = 2,
  parameter int SEG_BYTES = 64,
  parameter int SEG_IDX_W = 5,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int CNT_W     = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_err,
  input  logic [TS_W-1:0]       ts_in,
  input  logic [NPFX-1:0][63:0] pfx_addr,
  input  logic [NPFX-1:0]       pfx_en,
  output logic                  m_tvalid,
  output logic [7:0]            m_tdata,
  output logic                  m_tlast,
  output logic [SEG_IDX_W-1:0]  m_seg_idx,
  output logic                  m_seg_first,
  output logic                  m_seg_last,
  output logic                  sb_valid,
  output logic [TS_W-1:0]       sb_ts,
  output logic [CNT_W-1:0]      sb_len,
  output logic                  sb_fcs_ok,
  output logic                  sb_rx_err,
  output logic                  sb_len_err,
  output logic                  sb_pause,
  output logic [15:0]           sb_quanta,
  output logic                  sb_route
);
  localparam int HOLD = FCS_BYTES + 1;
  localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_LEN);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic [TS_W-1:0]  ts_q;
  logic             take, sfd_hit, fin;
  logic             crc_good, pause_hit, route_hit;
  logic [15:0]      quanta;

  assign sfd_hit = (state_q == ST_PRE) && rx_valid && (rx_data == SFD_BYTE);
  assign take    = (state_q == ST_DATA) && rx_valid;
  assign fin     = (state_q == ST_DATA) && !rx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (rx_valid) state_q <= (rx_data == PRE_BYTE) ? ST_PRE : ST_DROP;
        ST_PRE: begin
          if (!rx_valid)                  state_q <= ST_IDLE;
          else if (rx_data == SFD_BYTE)   state_q <= ST_DATA;
          else if (rx_data != PRE_BYTE)   state_q <= ST_DROP;
        end
        ST_DATA: if (!rx_valid) state_q <= ST_IDLE;
        default: if (!rx_valid) state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      ts_q  <= '0;
    end else if (sfd_hit) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      ts_q  <= ts_in;
    end else if (take) begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (rx_err)      err_q <= 1'b1;
    end
  end

  rxm_crc u_crc (
    .clk(clk), .rst(rst), .start(sfd_hit), .en(take), .data(rx_data), .good(crc_good)
  );

  rxm_classify #(.CNT_W(CNT_W), .NPFX(NPFX)) u_cls (
    .clk(clk), .rst(rst), .start(sfd_hit), .en(take), .idx(cnt_q), .data(rx_data),
    .pfx_addr(pfx_addr), .pfx_en(pfx_en),
    .pause_hit(pause_hit), .quanta(quanta), .route_hit(route_hit)
  );

  rxm_seg #(.SEG_BYTES(SEG_BYTES), .SEG_IDX_W(SEG_IDX_W), .HOLD(HOLD)) u_seg (
    .clk(clk), .rst(rst), .start(sfd_hit), .push(take), .fin(fin), .din(rx_data),
    .o_valid(m_tvalid), .o_data(m_tdata), .o_last(m_tlast), .o_idx(m_seg_idx),
    .o_first(m_seg_first), .o_end(m_seg_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sb_valid   <= 1'b0;
      sb_ts      <= '0;
      sb_len     <= '0;
      sb_fcs_ok  <= 1'b0;
      sb_rx_err  <= 1'b0;
      sb_len_err <= 1'b0;
      sb_pause   <= 1'b0;
      sb_quanta  <= '0;
      sb_route   <= 1'b0;
    end else begin
      sb_valid <= fin;
      if (fin) begin
        sb_ts      <= ts_q;
        sb_len     <= cnt_q;
        sb_fcs_ok  <= crc_good;
        sb_rx_err  <= err_q;
        sb_len_err <= (cnt_q < LEN_MIN) || (cnt_q > LEN_MAX);
        sb_pause   <= pause_hit && crc_good && !err_q;
        sb_quanta  <= quanta;
        sb_route   <= route_hit;
      end
    end
  end
endmodule

// File: rtl/rx_seg_mac_chk.sv
module rx_seg_mac_chk #(
  parameter int SEG_BYTES = 64,
  parameter int SEG_IDX_W = 5,
  parameter int MIN_LEN   = 64,
  parameter int CNT_W     = 11
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 m_tvalid,
  input logic                 m_tlast,
  input logic [SEG_IDX_W-1:0] m_seg_idx,
  input logic                 m_seg_first,
  input logic                 m_seg_last,
  input logic                 sb_valid,
  input logic [CNT_W-1:0]     sb_len,
  input logic                 sb_fcs_ok,
  input logic                 sb_rx_err,
  input logic                 sb_len_err,
  input logic                 sb_pause
);
  localparam int BW = $clog2(SEG_BYTES) + 1;
  localparam logic [BW-1:0]    BEAT_LAST = BW'(SEG_BYTES - 1);
  localparam logic [CNT_W-1:0] LEN_MIN   = CNT_W'(MIN_LEN);

  logic [BW-1:0] beat_q;
  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else if (m_tvalid) beat_q <= m_tlast ? '0 : beat_q + 1'b1;
  end

  a_r3_tlast_on_full: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && beat_q == BEAT_LAST |-> m_tlast);
  a_r3_tlast_not_early: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tlast && !m_seg_last |-> beat_q == BEAT_LAST);
  a_r3_first_is_zero: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_seg_first |-> m_seg_idx == '0);
  a_r10_end_with_sideband: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_seg_last |-> sb_valid && m_tlast);
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    sb_valid |=> !sb_valid);
  a_r6_short_flagged: assert property (@(posedge clk) disable iff (rst)
    sb_valid && sb_len < LEN_MIN |-> sb_len_err);
  a_r8_pause_clean: assert property (@(posedge clk) disable iff (rst)
    sb_valid && sb_pause |-> sb_fcs_ok && !sb_rx_err);
endmodule

bind rx_seg_mac rx_seg_mac_chk #(
  .SEG_BYTES(SEG_BYTES), .SEG_IDX_W(SEG_IDX_W), .MIN_LEN(MIN_LEN), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_seg_idx(m_seg_idx),
  .m_seg_first(m_seg_first), .m_seg_last(m_seg_last), .sb_valid(sb_valid),
  .sb_len(sb_len), .sb_fcs_ok(sb_fcs_ok), .sb_rx_err(sb_rx_err),
  .sb_len_err(sb_len_err), .sb_pause(sb_pause)
);

// File: tb/rx_seg_mac_tb_top.sv
module rx_seg_mac_tb_top;
  localparam int TS_W = 32;
  localparam int NPFX = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, rx_valid, rx_err;
  logic [7:0] rx_data;
  logic [TS_W-1:0] tsc = '0;
  logic [NPFX-1:0][63:0] pfx_addr;
  logic [NPFX-1:0] pfx_en;

  logic m_tvalid, m_tlast, m_seg_first, m_seg_last;
  logic [7:0] m_tdata;
  logic [4:0] m_seg_idx;
  logic sb_valid, sb_fcs_ok, sb_rx_err, sb_len_err, sb_pause, sb_route;
  logic [TS_W-1:0] sb_ts;
  logic [10:0] sb_len;
  logic [15:0] sb_quanta;

  rx_seg_mac dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .ts_in(tsc), .pfx_addr(pfx_addr), .pfx_en(pfx_en),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_seg_idx(m_seg_idx),
    .m_seg_first(m_seg_first), .m_seg_last(m_seg_last),
    .sb_valid(sb_valid), .sb_ts(sb_ts), .sb_len(sb_len), .sb_fcs_ok(sb_fcs_ok),
    .sb_rx_err(sb_rx_err), .sb_len_err(sb_len_err), .sb_pause(sb_pause),
    .sb_quanta(sb_quanta), .sb_route(sb_route)
  );

  always @(posedge clk) tsc <= tsc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] frm [0:1599];
  logic [7:0] cap_d [0:1599];
  logic       cap_l [0:1599];
  logic       cap_f [0:1599];
  logic       cap_e [0:1599];
  logic [4:0] cap_i [0:1599];
  int ncap = 0;
  int nsb  = 0;
  logic [TS_W-1:0] s_ts;
  logic [10:0] s_len;
  logic s_ok, s_err, s_lerr, s_pause, s_route;
  logic [15:0] s_q;
  logic [TS_W-1:0] exp_ts;

  always @(negedge clk) begin
    if (!rst) begin
      if (m_tvalid && ncap < 1600) begin
        cap_d[ncap] = m_tdata; cap_l[ncap] = m_tlast; cap_f[ncap] = m_seg_first;
        cap_e[ncap] = m_seg_last; cap_i[ncap] = m_seg_idx;
        ncap++;
      end
      if (sb_valid) begin
        nsb++;
        s_ts = sb_ts; s_len = sb_len; s_ok = sb_fcs_ok; s_err = sb_rx_err;
        s_lerr = sb_len_err; s_pause = sb_pause; s_q = sb_quanta; s_route = sb_route;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_calc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ frm[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return ~c;
  endfunction

  task automatic drive(input logic v, input logic [7:0] d, input logic e);
    @(posedge clk); #1;
    rx_valid = v; rx_data = d; rx_err = e;
  endtask

  // n bytes in frm, then 4 FCS bytes; err_at marks an rx_err byte (-1 none)
  task automatic send(input int n, input bit bad_fcs, input int err_at, input int npre, input logic [7:0] sfd);
    logic [31:0] f;
    f = crc_calc(n);
    if (bad_fcs) f = f ^ 32'h0000_0100;
    ncap = 0; nsb = 0;
    for (int i = 0; i < npre; i++) drive(1'b1, 8'h55, 1'b0);
    drive(1'b1, sfd, 1'b0);
    exp_ts = tsc;
    for (int i = 0; i < n; i++) drive(1'b1, frm[i], (i == err_at));
    for (int i = 0; i < 4; i++) drive(1'b1, f[8*i +: 8], 1'b0);
    drive(1'b0, 8'h00, 1'b0);
    repeat (12) @(posedge clk);
  endtask

  task automatic verify(input int n, input bit fok, input bit rerr, input bit pz, input logic [15:0] q, input bit rt);
    int bad_d, bad_l, bad_i, bad_f, bad_e;
    bit lerr;
    bad_d = 0; bad_l = 0; bad_i = 0; bad_f = 0; bad_e = 0;
    chk(ncap == n, "R2", "beat count", ncap, n);
    for (int i = 0; i < n && i < ncap; i++) begin
      if (cap_d[i] !== frm[i]) bad_d++;
      if (cap_l[i] !== ((i % 64) == 63 || i == n - 1)) bad_l++;
      if (cap_i[i] !== 5'(i / 64)) bad_i++;
      if (cap_f[i] !== (i < 64)) bad_f++;
      if (cap_e[i] !== (i == n - 1)) bad_e++;
    end
    chk(bad_d == 0, "R2", "data mismatches", bad_d, 0);
    chk(bad_l == 0, "R3", "tlast mismatches", bad_l, 0);
    chk(bad_i == 0 && bad_f == 0 && bad_e == 0, "R3", "index/first/last mismatches", bad_i + bad_f + bad_e, 0);
    chk(nsb == 1, "R10", "sideband strobes", nsb, 1);
    chk(s_ts == exp_ts, "R4", "timestamp", s_ts, exp_ts);
    lerr = (n + 4 < 64) || (n + 4 > 1518);
    chk(s_len == 11'(n + 4) && s_lerr == lerr, "R6", "length/len_err", {s_len, s_lerr}, {11'(n + 4), lerr});
    chk(s_ok == fok, "R5", "fcs_ok", s_ok, fok);
    chk(s_err == rerr, "R7", "rx_err flag", s_err, rerr);
    chk(s_pause == pz && (!pz || s_q == q), "R8", "pause/quanta", {s_pause, s_q}, {pz, q});
    chk(s_route == rt, "R9", "route", s_route, rt);
  endtask

  task automatic fill_plain(input int n, input int seed);
    for (int i = 0; i < n; i++) frm[i] = 8'((i * 7 + seed) & 255);
  endtask

  task automatic fill_pause(input logic [7:0] op_lo);
    for (int i = 0; i < 60; i++) frm[i] = 8'h00;
    frm[0] = 8'h01; frm[1] = 8'h80; frm[2] = 8'hC2; frm[5] = 8'h01;
    for (int i = 6; i < 12; i++) frm[i] = 8'(16 + i);
    frm[12] = 8'h88; frm[13] = 8'h08; frm[14] = 8'h00; frm[15] = op_lo;
    frm[16] = 8'h12; frm[17] = 8'h34;
  endtask

  task automatic fill_v6(input logic [63:0] p);
    fill_plain(100, 3);
    frm[12] = 8'h86; frm[13] = 8'hDD;
    for (int i = 0; i < 8; i++) frm[38 + i] = p[8*(7 - i) +: 8];
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rx_valid = 1'b0; rx_data = 8'h00; rx_err = 1'b0;
    pfx_addr[0] = 64'hFD00_1111_2222_3333;
    pfx_addr[1] = 64'h2001_0DB8_0000_0001;
    pfx_en = 2'b11;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(m_tvalid == 1'b0 && sb_valid == 1'b0, "R10", "outputs idle in reset", {m_tvalid, sb_valid}, 0);
    #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_tvalid == 1'b0 && sb_valid == 1'b0, "R10", "outputs idle after reset", {m_tvalid, sb_valid}, 0);

    // length sweep across segment boundaries, including runts (R2, R3, R6)
    for (int n = 0; n <= 200; n++) begin
      fill_plain(n, n);
      send(n, 1'b0, -1, 7, 8'hD5);
      verify(n, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0);
    end

    // short preamble still accepted (R1)
    fill_plain(70, 9); send(70, 1'b0, -1, 1, 8'hD5); verify(70, 1'b1, 1'b0, 1'b0, 0, 1'b0);

    // bad CRC: data still forwarded (R5)
    fill_plain(90, 5); send(90, 1'b1, -1, 7, 8'hD5); verify(90, 1'b0, 1'b0, 1'b0, 0, 1'b0);

    // receive error mid-frame (R7)
    fill_plain(80, 2); send(80, 1'b0, 30, 7, 8'hD5); verify(80, 1'b1, 1'b1, 1'b0, 0, 1'b0);

    // pause frame, wrong opcode, bad CRC (R8)
    fill_pause(8'h01); send(60, 1'b0, -1, 7, 8'hD5); verify(60, 1'b1, 1'b0, 1'b1, 16'h1234, 1'b0);
    fill_pause(8'h02); send(60, 1'b0, -1, 7, 8'hD5); verify(60, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    fill_pause(8'h01); send(60, 1'b1, -1, 7, 8'hD5); verify(60, 1'b0, 1'b0, 1'b0, 0, 1'b0);

    // route classification (R9)
    fill_v6(64'h2001_0DB8_0000_0001); send(100, 1'b0, -1, 7, 8'hD5); verify(100, 1'b1, 1'b0, 1'b0, 0, 1'b1);
    fill_v6(64'hFD00_1111_2222_3333); send(100, 1'b0, -1, 7, 8'hD5); verify(100, 1'b1, 1'b0, 1'b0, 0, 1'b1);
    fill_v6(64'h2001_0DB8_0000_0002); send(100, 1'b0, -1, 7, 8'hD5); verify(100, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    pfx_en = 2'b01;
    fill_v6(64'h2001_0DB8_0000_0001); send(100, 1'b0, -1, 7, 8'hD5); verify(100, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    pfx_en = 2'b11;

    // maximum and oversize lengths (R6)
    fill_plain(1514, 4); send(1514, 1'b0, -1, 7, 8'hD5); verify(1514, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    fill_plain(1515, 6); send(1515, 1'b0, -1, 7, 8'hD5); verify(1515, 1'b1, 1'b0, 1'b0, 0, 1'b0);

    // rejected starts: wrong delimiter, delimiter without preamble (R1)
    fill_plain(80, 1); send(80, 1'b0, -1, 3, 8'h5A);
    chk(ncap == 0 && nsb == 0, "R1", "bad delimiter output", ncap + nsb, 0);
    fill_plain(80, 1); send(80, 1'b0, -1, 0, 8'hD5);
    chk(ncap == 0 && nsb == 0, "R1", "missing preamble output", ncap + nsb, 0);

    // recovery after rejection (R1)
    fill_plain(66, 8); send(66, 1'b0, -1, 7, 8'hD5); verify(66, 1'b1, 1'b0, 1'b0, 0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule